// File: doc/BRIEF.md
# Ones' Complement Sequential Multiplier

This block multiplies two 16-bit ones' complement fractions over several clock cycles. A one-cycle start pulse captures the accumulator operand (`acc_i`, the multiplier) and the memory operand (`mem_i`, the multiplicand), together with an ending select (`round_i`). Each operand that has its sign bit set is inverted to its magnitude, and every such inversion toggles an internal product sign.

The magnitudes are multiplied by shift-and-add. The multiplier sits in the low register. A set low bit triggers a partial add of the multiplicand into the high register. That partial add keeps its carries in a separate carry register. A clear low bit shifts the high:low pair right by one and resolves one level of pending carry. After fifteen shifts, the leftover carries are resolved with an end-around carry. Then comes the chosen ending:
- **Round:** a 1 is added when the low word's top bit is set, and the low word is cleared.
- **Hold:** the low word is kept.

Last, the high word is inverted if the product is negative. The outputs hold the result until the next operation. `done_o` marks the cycle in which the result first becomes valid.

Top module: `oc_mult`

## Requirements
- R1: While reset is active, and after its release until the first start, `done_o`, `ac_o` and `br_o` are all 0.
- R2: An operand is negative when its bit 15 is 1. This includes negative zero, 16'hFFFF. The result high word is inverted (all bits) exactly when one of the two operands is negative. The low word is never inverted.
- R3: With `round_i`=0 at start (hold), let M be the 32-bit value 2·|acc|·|mem|, using the magnitudes. Before the sign step, {`ac_o`,`br_o`} equals M.
- R4: With `round_i`=1 at start (round), the high word of M is incremented when bit 15 of the low word of M is 1. This happens before the sign step. `br_o` reads 0 at done.
- R5: `done_o` is high for exactly one cycle. That cycle follows the start edge by 17 + popcount(|acc|[14:0]) rising edges.
- R6: A start pulse that arrives while an operation is in progress is ignored. The result depends only on the operands and mode captured at the accepted start.
- R7: The largest magnitude, 16'o077777, multiplied by itself gives 16'o077776 in the high word in both modes, with low word 16'h0002 in hold mode. A zero magnitude on either side gives a zero product, which is negative zero (16'hFFFF) when the signs differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled when idle |
| round_i | input | 1 | 1 = round ending, 0 = hold low half |
| acc_i | input | 16 | Multiplier operand (accumulator value) |
| mem_i | input | 16 | Multiplicand operand (memory word) |
| ac_o | output | 16 | High product word |
| br_o | output | 16 | Low product word |
| done_o | output | 1 | One-cycle result-valid strobe |

## Verification
The situation hardest to bring about from the ports is a chain of deferred carries that is still pending when the loop ends. It needs dense multiplier bit patterns against large multiplicands, so the stimulus includes all-ones magnitudes, alternating patterns and a long pseudo-random sweep. The bench also pulses start, with different operands and mode, during an operation in progress. This shows that the late request neither restarts the operation nor alters its result.

// File: rtl/oc_mult_pkg.sv
package oc_mult_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOP,
    ST_RESOLVE,
    ST_SIGN
  } state_e;
endpackage

// File: rtl/oc_mult_abs.sv
module oc_mult_abs #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] mag_o,
  output logic         neg_o
);
  assign neg_o = val_i[W-1];
  assign mag_o = neg_o ? ~val_i : val_i;
endmodule

// File: rtl/oc_mult_step.sv
module oc_mult_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] br_i,
  input  logic [W-1:0] ar_i,
  input  logic [W-1:0] cry_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] br_o,
  output logic [W-1:0] cry_o,
  output logic         shift_o
);
  logic [W-1:0] ac_sh;

  assign shift_o = ~br_i[0];
  assign ac_sh   = ac_i >> 1;

  always_comb begin
    if (br_i[0]) begin
      // partial add: carries parked, not propagated
      cry_o = cry_i | (ac_i & ar_i);
      ac_o  = ac_i ^ ar_i;
      br_o  = {br_i[W-1:1], 1'b0};
    end else begin
      // shift pair right, resolve one carry level
      br_o  = {ac_i[0], br_i[W-1:1]};
      ac_o  = ac_sh ^ cry_i;
      cry_o = cry_i & ac_sh;
    end
  end
endmodule

// File: rtl/oc_mult_resolve.sv
module oc_mult_resolve #(
  parameter int W = 16
) (
  input  logic [W-1:0] ac_i,
  input  logic [W-1:0] cry_i,
  input  logic         rnd_i,
  output logic [W-1:0] ac_o
);
  logic [W:0] sum1;
  logic [W:0] sum2;

  assign sum1 = {1'b0, ac_i} + {cry_i, 1'b0};
  assign sum2 = {1'b0, sum1[W-1:0]} + {{W{1'b0}}, sum1[W]} + {{W{1'b0}}, rnd_i};
  assign ac_o = sum2[W-1:0] + {{(W-1){1'b0}}, sum2[W]};
endmodule

// File: rtl/oc_mult.sv
module oc_mult
  import oc_mult_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         round_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mem_i,
  output logic [W-1:0] ac_o,
  output logic [W-1:0] br_o,
  output logic         done_o
);
  localparam int STEPS = W - 1;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  state_e       state_q;
  logic [W-1:0] ac_q, br_q, ar_q, cry_q;
  logic [CW-1:0] cnt_q;
  logic         sign_q, round_q, done_q;

  logic [W-1:0] mc_mag, md_mag;
  logic         mc_neg, md_neg;
  logic [W-1:0] st_ac, st_br, st_cry, res_ac;
  logic         st_shift;

  oc_mult_abs #(.W(W)) u_abs_mc (.val_i(acc_i), .mag_o(mc_mag), .neg_o(mc_neg));
  oc_mult_abs #(.W(W)) u_abs_md (.val_i(mem_i), .mag_o(md_mag), .neg_o(md_neg));

  oc_mult_step #(.W(W)) u_step (
    .ac_i(ac_q), .br_i(br_q), .ar_i(ar_q), .cry_i(cry_q),
    .ac_o(st_ac), .br_o(st_br), .cry_o(st_cry), .shift_o(st_shift)
  );

  oc_mult_resolve #(.W(W)) u_resolve (
    .ac_i(ac_q), .cry_i(cry_q), .rnd_i(round_q & br_q[W-1]), .ac_o(res_ac)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ac_q    <= '0;
      br_q    <= '0;
      ar_q    <= '0;
      cry_q   <= '0;
      cnt_q   <= '0;
      sign_q  <= 1'b0;
      round_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ac_q    <= '0;
          br_q    <= mc_mag;
          ar_q    <= md_mag;
          cry_q   <= '0;
          cnt_q   <= '0;
          sign_q  <= mc_neg ^ md_neg;
          round_q <= round_i;
          state_q <= ST_LOOP;
        end
        ST_LOOP: begin
          ac_q  <= st_ac;
          br_q  <= st_br;
          cry_q <= st_cry;
          if (st_shift) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) state_q <= ST_RESOLVE;
          end
        end
        ST_RESOLVE: begin
          ac_q  <= res_ac;
          cry_q <= '0;
          if (round_q) br_q <= '0;
          state_q <= ST_SIGN;
        end
        ST_SIGN: begin
          if (sign_q) ac_q <= ~ac_q;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ac_o   = ac_q;
  assign br_o   = br_q;
  assign done_o = done_q;
endmodule

// File: rtl/oc_mult_chk.sv
module oc_mult_chk
  import oc_mult_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          done_o,
  input logic [W-1:0]  br_o,
  input state_e        state_q,
  input logic [W-1:0]  ar_q,
  input logic          round_q,
  input logic [CW-1:0] cnt_q
);
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> state_q == ST_IDLE);

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOOP |-> cnt_q < CW'(W - 1));

  assert_round_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && round_q) |-> br_o == '0);

  assert_start_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && start_i) |=> $stable(ar_q));

  assert_magnitude_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE |-> !ar_q[W-1]);
endmodule

bind oc_mult oc_mult_chk #(.W(W), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o),
  .br_o(br_o), .state_q(state_q), .ar_q(ar_q), .round_q(round_q), .cnt_q(cnt_q)
);

// File: tb/oc_mult_tb.sv
`timescale 1ns/1ps
module oc_mult_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rnd = 1'b0;
  logic [15:0] acc = '0;
  logic [15:0] mem = '0;
  logic [15:0] ac_o, br_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  int          m_busy = 0;
  logic        m_done = 1'b0;
  logic [15:0] m_ac = '0, m_br = '0;
  logic [15:0] p_ac = '0, p_br = '0;
  string       cur_tag = "R1";
  string       m_tag = "R1";

  always #10 clk = ~clk;

  oc_mult u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .round_i(rnd),
    .acc_i(acc), .mem_i(mem), .ac_o(ac_o), .br_o(br_o), .done_o(done_o)
  );

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b,
                                          input logic r);
    logic [15:0] ma, mb, hi, lo;
    logic [31:0] p;
    ma = a[15] ? ~a : a;
    mb = b[15] ? ~b : b;
    p  = ({16'b0, ma} * {16'b0, mb}) << 1;
    hi = p[31:16];
    lo = p[15:0];
    if (r) begin
      hi = hi + {15'b0, lo[15]};
      lo = '0;
    end
    if (a[15] ^ b[15]) hi = ~hi;
    return {hi, lo};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0;
      m_done = 1'b0;
      m_ac   = '0;
      m_br   = '0;
    end else begin
      m_done = 1'b0;
      if (m_busy > 0) begin
        m_busy = m_busy - 1;
        if (m_busy == 0) begin
          m_done = 1'b1;
          m_ac   = p_ac;
          m_br   = p_br;
        end
      end else if (start) begin
        logic [31:0] r;
        logic [15:0] mb;
        r      = ref_mul(acc, mem, rnd);
        p_ac   = r[31:16];
        p_br   = r[15:0];
        mb     = acc[15] ? ~acc : acc;
        m_busy = 17 + $countones(mb[14:0]);
        m_tag  = cur_tag;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (done_o !== m_done) begin
        n_fail++;
        $display("FAIL R5 done_o actual=%b expected=%b", done_o, m_done);
      end
      if (m_done) begin
        n_chk++;
        if (ac_o !== m_ac || br_o !== m_br) begin
          n_fail++;
          $display("FAIL %s ac/br actual=%06o/%06o expected=%06o/%06o",
                   m_tag, ac_o, br_o, m_ac, m_br);
        end
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy > 0 || m_done) @(negedge clk);
  endtask

  task automatic op(input logic [15:0] a, input logic [15:0] b, input logic r,
                    input string tag);
    @(negedge clk);
    acc = a; mem = b; rnd = r; start = 1'b1; cur_tag = tag;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  // R6: extra starts with other operands while busy
  task automatic op_busy(input logic [15:0] a, input logic [15:0] b, input logic r);
    @(negedge clk);
    acc = a; mem = b; rnd = r; start = 1'b1; cur_tag = "R6";
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      repeat (3) @(negedge clk);
      acc = 16'o012345 + 16'(k); mem = 16'o154321; rnd = ~r; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (2) @(negedge clk);
    n_chk++;
    if (done_o !== 1'b0 || ac_o !== '0 || br_o !== '0) begin
      n_fail++;
      $display("FAIL R1 reset actual=%b/%06o/%06o expected=0/0/0", done_o, ac_o, br_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_chk++;
    if (done_o !== 1'b0 || ac_o !== '0 || br_o !== '0) begin
      n_fail++;
      $display("FAIL R1 idle actual=%b/%06o/%06o expected=0/0/0", done_o, ac_o, br_o);
    end

    op(16'o040000, 16'o040000, 1'b0, "R3");
    op(16'o012345, 16'o054321, 1'b0, "R3");
    op(16'o052525, 16'o077777, 1'b0, "R3");
    op(16'o012345, 16'o054321, 1'b1, "R4");
    op(16'o077777, 16'o000001, 1'b1, "R4");
    op(~16'o012345, 16'o054321, 1'b0, "R2");
    op(16'o012345, ~16'o054321, 1'b1, "R2");
    op(~16'o012345, ~16'o054321, 1'b1, "R2");
    op(16'o077777, 16'o077777, 1'b0, "R7");
    op(16'o077777, 16'o077777, 1'b1, "R7");
    op(16'o100000, 16'o077777, 1'b0, "R7");
    op(16'o000000, 16'hFFFF, 1'b0, "R7");
    op(16'hFFFF, 16'hFFFF, 1'b1, "R7");
    op(16'o000000, 16'o077777, 1'b1, "R7");
    op(16'o077777, 16'o000000, 1'b0, "R5");
    op_busy(16'o063146, 16'o071625, 1'b0);
    op_busy(~16'o033333, 16'o044444, 1'b1);

    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a, b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr ^ 16'h5A5A;
      op(a, b, lfsr[3], (i % 2 == 0) ? "R3" : "R4");
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule